// File: doc/BRIEF.md
# Idle Drive-Polling Sequencer for a Floppy Disk Controller

This block governs what a floppy disk controller does while no command is running. A prescaler counts clock cycles. The count it uses depends on the selected data rate. Each time the count expires, the block runs one polling pass. A pass visits the four logical drives in turn and spends a fixed number of cycles on each drive. During a drive's visit the block emits a single STEP pulse, with the matching DIR level, if that drive still needs to step. The same pass instants also clock a delayed power-down timer.

Each hardware or soft reset arms a one-shot event. On the first pass after the reset, all four per-drive status-change flags are raised and the interrupt output is asserted. The host then clears the flags one at a time with sense strobes. The event is suppressed only if polling is disabled by a configuration write that lands within a short window after the reset. Stepping and the power-down timer keep running when polling is disabled.

The block also produces the request-for-master and direction bits of the host status. The first opcode byte moves the block into a command phase, and no passes run during that phase. If an opcode byte arrives while a pass is running, the request bit is held low until the pass finishes.

Top module: `fdc_poll_seq`

## Requirements
- R1: After reset, rqm_o is 1, dio_o is 0, msr_drv_o is 0000, and irq_o, step_o and pd_req_o are 0.
- R2: A cmd_byte_i strobe while idle enters the command phase. rqm_o stays 1, and no polling pass starts until cmd_done_i is pulsed. Passes resume afterwards.
- R3: While the block is not in the command phase, a pass starts every POLL_CYC cycles when rate_sel_i is 00 (500 kbps), 10 (1 Mbps) or 11. It starts every 2*POLL_CYC cycles when rate_sel_i is 01 (250 kbps).
- R4: A pass keeps poll_act_o high for 4*SLOT_CYC cycles. It visits drives 0, 1, 2, 3 in that order, for SLOT_CYC cycles each.
- R5: After a hardware reset or a soft_rst_i pulse, the first pass sets all four bits of msr_drv_o (bit n is drive n) and asserts irq_o.
- R6: Each sense_i strobe clears the lowest-numbered set bit of msr_drv_o, and only that bit. irq_o is 1 exactly while any bit remains set. A strobe with no bit set has no effect.
- R7: A cfg_wr_i strobe with cfg_poll_dis_i=1 within CFG_WIN_CYC cycles after reset keeps R5 from setting any flag. The same write made later has no effect.
- R8: During a drive's visit, if step_need_i[n] is 1, step_o is high for exactly the first cycle of the visit, with step_drv_o=n and dir_o=step_dir_i[n]. This holds whether or not polling is disabled.
- R9: A cmd_byte_i strobe during a pass drives rqm_o low from the next cycle until the pass ends. rqm_o then returns to 1 and the command phase begins.
- R10: While motor_off_i and auto_pd_en_i are both held at 1, pd_req_o rises at the PD_WAIT-th pass start. It returns to 0 in the cycle after either input drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous soft reset pulse, same effect as rst_n |
| rate_sel_i | input | 2 | Data-rate select: 00 500k, 01 250k, 10 1M, 11 as 500k |
| cmd_byte_i | input | 1 | Opcode byte written by host (one-cycle strobe) |
| cmd_done_i | input | 1 | Command finished, return to idle |
| sense_i | input | 1 | Sense-interrupt strobe, clears one flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_poll_dis_i | input | 1 | Polling-disable bit carried by cfg_wr_i |
| step_need_i | input | 4 | Per-drive step request |
| step_dir_i | input | 4 | Per-drive step direction |
| motor_off_i | input | 1 | Motor-off time limit has expired |
| auto_pd_en_i | input | 1 | Automatic power-down enabled |
| rqm_o | output | 1 | Request for master status bit |
| dio_o | output | 1 | Data direction status bit (0: host to controller) |
| msr_drv_o | output | 4 | Per-drive status-change flags |
| irq_o | output | 1 | Interrupt request |
| poll_act_o | output | 1 | Polling pass in progress |
| step_o | output | 1 | Head step pulse |
| dir_o | output | 1 | Step direction |
| step_drv_o | output | 2 | Drive addressed by the current step |
| pd_req_o | output | 1 | Power-down request |

## Verification
The hardest case to reach is an opcode byte that lands inside the short pass window. The stimulus waits until poll_act_o rises, strobes cmd_byte_i on the following cycle, and then follows rqm_o until the pass ends and afterwards through a command phase with no passes. The reset window for disabling polling is a second timing-sensitive case. It is covered by repeating the reset twice, once with the configuration write a few cycles after reset and once with the write after the window but before the first pass. The first run must show no flags and the second all four.

// File: rtl/fdc_poll_pkg.sv
// Package: shared types and rate codes for the idle polling sequencer.
// Assumes: the two-bit rate select follows the encoding stated in the brief.
package fdc_poll_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_POLL = 2'd1,
        PH_CMD  = 2'd2
    } phase_t;

    localparam logic [1:0] RATE_250K = 2'b01;
endpackage

// File: rtl/fdc_poll_timebase.sv
// Module: pass-interval prescaler. Produces one tick per polling period.
// The period doubles at 250 kbps. Assumes: run_i is low during the command phase.
module fdc_poll_timebase
    import fdc_poll_pkg::*;
#(
    parameter int POLL_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int CW = $clog2(2 * POLL_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Select the terminal count from the data rate
    assign lim = (rate_i == RATE_250K) ? CW'(2 * POLL_CYC - 1) : CW'(POLL_CYC - 1);

    // Period counter, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clr_i || !run_i)   cnt_q <= '0;
        else if (cnt_q >= lim)      cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q >= lim);
endmodule

// File: rtl/fdc_poll_flags.sv
// Module: reset-triggered per-drive status flags and the interrupt.
// Reset arms a one-shot. The first scan after reset raises all four flags unless
// polling was disabled within the post-reset window. Sense strobes clear the flags lowest first.
module fdc_poll_flags #(
    parameter int CFG_WIN_CYC = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       cfg_wr_i,
    input  logic       cfg_poll_dis_i,
    input  logic       scan_i,
    input  logic       sense_i,
    output logic [3:0] flags_o,
    output logic       irq_o
);
    localparam int WW = $clog2(CFG_WIN_CYC + 1);

    logic [WW-1:0] win_q;
    logic          win_open;
    logic          poll_off_q;
    logic          armed_q;
    logic [3:0]    flags_q;
    logic [3:0]    low_bit;

    assign win_open = (win_q < WW'(CFG_WIN_CYC));
    assign low_bit  = flags_q & (~flags_q + 4'd1);

    // Post-reset window counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  win_q <= '0;
        else if (win_open)    win_q <= win_q + 1'b1;
    end

    // Latch the polling-disable request only inside the window
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                              poll_off_q <= 1'b0;
        else if (cfg_wr_i && cfg_poll_dis_i && win_open)  poll_off_q <= 1'b1;
    end

    // One-shot ready-toggle event, armed by any reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  armed_q <= 1'b1;
        else if (scan_i)      armed_q <= 1'b0;
    end

    // Status flags: set by the armed scan, cleared one per sense strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)          flags_q <= '0;
        else if (scan_i && armed_q)   flags_q <= poll_off_q ? 4'b0000 : 4'b1111;
        else if (sense_i)             flags_q <= flags_q & ~low_bit;
    end

    assign flags_o = flags_q;
    assign irq_o   = |flags_q;
endmodule

// File: rtl/fdc_poll_pwrdn.sv
// Module: delayed automatic power-down counter. It counts pass starts while
// the motor-off limit has expired and auto power-down is enabled.
module fdc_poll_pwrdn #(
    parameter int PD_WAIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic motor_off_i,
    input  logic auto_en_i,
    output logic pd_req_o
);
    localparam int PW = $clog2(PD_WAIT + 1);

    logic [PW-1:0] cnt_q;
    logic          cond;

    assign cond = motor_off_i && auto_en_i;

    // Saturating pass counter, cleared when the condition drops
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                      cnt_q <= '0;
        else if (!cond)                           cnt_q <= '0;
        else if (tick_i && cnt_q < PW'(PD_WAIT))  cnt_q <= cnt_q + 1'b1;
    end

    assign pd_req_o = (cnt_q == PW'(PD_WAIT));
endmodule

// File: rtl/fdc_poll_seq.sv
// Module: idle-phase drive-polling sequencer (top).
// It runs periodic four-drive passes while idle, stepping drives that need it,
// and it holds RQM low when an opcode byte arrives during a pass.
// Assumes: 4*SLOT_CYC < POLL_CYC and SLOT_CYC >= 2.
module fdc_poll_seq
    import fdc_poll_pkg::*;
#(
    parameter int POLL_CYC    = 1000,
    parameter int SLOT_CYC    = 8,
    parameter int PD_WAIT     = 512,
    parameter int CFG_WIN_CYC = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst_i,
    input  logic [1:0] rate_sel_i,
    input  logic       cmd_byte_i,
    input  logic       cmd_done_i,
    input  logic       sense_i,
    input  logic       cfg_wr_i,
    input  logic       cfg_poll_dis_i,
    input  logic [3:0] step_need_i,
    input  logic [3:0] step_dir_i,
    input  logic       motor_off_i,
    input  logic       auto_pd_en_i,
    output logic       rqm_o,
    output logic       dio_o,
    output logic [3:0] msr_drv_o,
    output logic       irq_o,
    output logic       poll_act_o,
    output logic       step_o,
    output logic       dir_o,
    output logic [1:0] step_drv_o,
    output logic       pd_req_o
);
    localparam int SW = $clog2(SLOT_CYC);

    phase_t        phase_q;
    logic          cmd_pend_q;
    logic [1:0]    drv_q;
    logic [SW-1:0] slot_q;
    logic          tb_tick;
    logic          pass_start;
    logic          pass_last;
    logic          stepping;

    fdc_poll_timebase #(.POLL_CYC(POLL_CYC)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (soft_rst_i),
        .run_i  (phase_q != PH_CMD),
        .rate_i (rate_sel_i),
        .tick_o (tb_tick)
    );

    assign pass_start = tb_tick && (phase_q == PH_IDLE) && !cmd_byte_i;
    assign pass_last  = (phase_q == PH_POLL) && (drv_q == 2'd3) && (slot_q == SW'(SLOT_CYC - 1));

    fdc_poll_flags #(.CFG_WIN_CYC(CFG_WIN_CYC)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (soft_rst_i),
        .cfg_wr_i       (cfg_wr_i),
        .cfg_poll_dis_i (cfg_poll_dis_i),
        .scan_i         (pass_start),
        .sense_i        (sense_i),
        .flags_o        (msr_drv_o),
        .irq_o          (irq_o)
    );

    fdc_poll_pwrdn #(.PD_WAIT(PD_WAIT)) u_pwrdn (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (soft_rst_i),
        .tick_i      (pass_start),
        .motor_off_i (motor_off_i),
        .auto_en_i   (auto_pd_en_i),
        .pd_req_o    (pd_req_o)
    );

    // Phase machine: idle, polling pass, command
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (cmd_byte_i)      phase_q <= PH_CMD;
                         else if (pass_start) phase_q <= PH_POLL;
                PH_POLL: if (pass_last)       phase_q <= (cmd_pend_q || cmd_byte_i) ? PH_CMD : PH_IDLE;
                PH_CMD:  if (cmd_done_i)      phase_q <= PH_IDLE;
                default:                      phase_q <= PH_IDLE;
            endcase
        end
    end

    // Remember an opcode byte that arrived during a pass
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i)                  cmd_pend_q <= 1'b0;
        else if (phase_q != PH_POLL || pass_last)  cmd_pend_q <= 1'b0;
        else if (cmd_byte_i)                       cmd_pend_q <= 1'b1;
    end

    // Drive and slot counters walking drives 0..3
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i || phase_q != PH_POLL) begin
            drv_q  <= '0;
            slot_q <= '0;
        end else if (slot_q == SW'(SLOT_CYC - 1)) begin
            slot_q <= '0;
            drv_q  <= drv_q + 2'd1;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign stepping   = (phase_q == PH_POLL) && (slot_q == '0) && step_need_i[drv_q];
    assign step_o     = stepping;
    assign dir_o      = stepping && step_dir_i[drv_q];
    assign step_drv_o = drv_q;
    assign poll_act_o = (phase_q == PH_POLL);
    assign rqm_o      = !((phase_q == PH_POLL) && cmd_pend_q);
    assign dio_o      = 1'b0;
endmodule

// File: rtl/fdc_poll_chk.sv
// Module: property checker for fdc_poll_seq, attached by bind.
// It observes the top-level ports only.
module fdc_poll_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst_i,
    input logic       sense_i,
    input logic       motor_off_i,
    input logic       auto_pd_en_i,
    input logic       rqm_o,
    input logic [3:0] msr_drv_o,
    input logic       poll_act_o,
    input logic       step_o,
    input logic       pd_req_o
);
    // R9
    rqm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rqm_o |-> poll_act_o);

    // R9
    rqm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(poll_act_o) |-> rqm_o);

    // R8
    step_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> poll_act_o);

    // R8
    step_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R6
    sense_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i && !soft_rst_i && msr_drv_o != 4'd0) |=>
            ($countones(msr_drv_o) + 1 == $countones($past(msr_drv_o))));

    // R10
    pd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_req_o) |-> $past(motor_off_i && auto_pd_en_i));
endmodule

bind fdc_poll_seq fdc_poll_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .sense_i      (sense_i),
    .motor_off_i  (motor_off_i),
    .auto_pd_en_i (auto_pd_en_i),
    .rqm_o        (rqm_o),
    .msr_drv_o    (msr_drv_o),
    .poll_act_o   (poll_act_o),
    .step_o       (step_o),
    .pd_req_o     (pd_req_o)
);

// File: tb/test_fdc_poll_seq.sv
// Directed bench for fdc_poll_seq. Each task drives one scenario and checks its own results.
module test_fdc_poll_seq;
    localparam int POLL = 40;
    localparam int SLOT = 4;
    localparam int PDW  = 3;
    localparam int WIN  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_i = 1'b0;
    logic [1:0] rate_sel_i = 2'b00;
    logic       cmd_byte_i = 1'b0;
    logic       cmd_done_i = 1'b0;
    logic       sense_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic       cfg_poll_dis_i = 1'b0;
    logic [3:0] step_need_i = 4'b0000;
    logic [3:0] step_dir_i = 4'b0000;
    logic       motor_off_i = 1'b0;
    logic       auto_pd_en_i = 1'b0;
    logic       rqm_o, dio_o, irq_o, poll_act_o, step_o, dir_o, pd_req_o;
    logic [3:0] msr_drv_o;
    logic [1:0] step_drv_o;

    int n_chk = 0;
    int n_err = 0;
    logic act_prev = 1'b0;

    always #5 clk = ~clk;

    fdc_poll_seq #(.POLL_CYC(POLL), .SLOT_CYC(SLOT), .PD_WAIT(PDW), .CFG_WIN_CYC(WIN)) i_fdc_poll_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .rate_sel_i(rate_sel_i),
        .cmd_byte_i(cmd_byte_i), .cmd_done_i(cmd_done_i), .sense_i(sense_i),
        .cfg_wr_i(cfg_wr_i), .cfg_poll_dis_i(cfg_poll_dis_i), .step_need_i(step_need_i),
        .step_dir_i(step_dir_i), .motor_off_i(motor_off_i), .auto_pd_en_i(auto_pd_en_i),
        .rqm_o(rqm_o), .dio_o(dio_o), .msr_drv_o(msr_drv_o), .irq_o(irq_o),
        .poll_act_o(poll_act_o), .step_o(step_o), .dir_o(dir_o),
        .step_drv_o(step_drv_o), .pd_req_o(pd_req_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        act_prev = 1'b0;
    endtask

    // Advance to the negedge where poll_act_o is first seen high; returns cycles waited
    task automatic wait_pass(output int cyc);
        cyc = -1;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (poll_act_o && !act_prev) begin
                act_prev = 1'b1;
                cyc = i;
                break;
            end
            act_prev = poll_act_o;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && poll_act_o; i++) @(negedge clk);
        act_prev = poll_act_o;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(rqm_o == 1'b1 && dio_o == 1'b0, "R1 rqm/dio", {rqm_o, dio_o}, 2);
        chk(msr_drv_o == 4'd0 && !irq_o, "R1 flags", msr_drv_o, 0);
        chk(!step_o && !pd_req_o && !poll_act_o, "R1 step/pd", {step_o, pd_req_o}, 0);
    endtask

    task automatic t_rates();
        int c;
        int len;
        int exp_p [4] = '{POLL, 2 * POLL, POLL, POLL};
        for (int r = 0; r < 4; r++) begin
            rate_sel_i = 2'(r);
            wait_pass(c);
            wait_pass(c);
            chk(c == exp_p[r], $sformatf("R3 period rate %0d", r), c, exp_p[r]);
        end
        rate_sel_i = 2'b00;
        wait_pass(c);
        len = 0;
        while (poll_act_o && len < 100) begin
            len++;
            @(negedge clk);
        end
        act_prev = poll_act_o;
        chk(len == 4 * SLOT, "R4 pass length", len, 4 * SLOT);
    endtask

    task automatic t_flags_sense();
        int c;
        logic [3:0] exp_f [4] = '{4'b1110, 4'b1100, 4'b1000, 4'b0000};
        do_reset();
        wait_pass(c);
        chk(msr_drv_o == 4'b1111 && irq_o, "R5 flags after reset", msr_drv_o, 15);
        for (int k = 0; k < 4; k++) begin
            sense_i = 1'b1;
            @(negedge clk);
            sense_i = 1'b0;
            chk(msr_drv_o == exp_f[k], "R6 sense clear order", msr_drv_o, exp_f[k]);
        end
        chk(!irq_o, "R6 irq drops", irq_o, 0);
        sense_i = 1'b1;
        @(negedge clk);
        sense_i = 1'b0;
        chk(msr_drv_o == 4'd0 && !irq_o, "R6 sense with no flag", msr_drv_o, 0);
        soft_rst_i = 1'b1;
        @(negedge clk);
        soft_rst_i = 1'b0;
        act_prev = 1'b0;
        chk(msr_drv_o == 4'd0, "R5 soft reset clears", msr_drv_o, 0);
        wait_pass(c);
        chk(msr_drv_o == 4'b1111, "R5 flags after soft reset", msr_drv_o, 15);
    endtask

    task automatic t_poll_disable();
        int c;
        do_reset();
        repeat (2) @(negedge clk);
        cfg_wr_i = 1'b1; cfg_poll_dis_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_poll_dis_i = 1'b0;
        wait_pass(c);
        chk(msr_drv_o == 4'd0 && !irq_o, "R7 early disable", msr_drv_o, 0);
        do_reset();
        repeat (20) @(negedge clk);
        cfg_wr_i = 1'b1; cfg_poll_dis_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_poll_dis_i = 1'b0;
        wait_pass(c);
        chk(msr_drv_o == 4'b1111, "R7 late disable ignored", msr_drv_o, 15);
    endtask

    task automatic t_step(input logic [3:0] need, input logic [3:0] dir, input bool_dis);
        int c;
        int pulses;
        int bad;
        do_reset();
        if (bool_dis) begin
            cfg_wr_i = 1'b1; cfg_poll_dis_i = 1'b1;
            @(negedge clk);
            cfg_wr_i = 1'b0; cfg_poll_dis_i = 1'b0;
        end
        step_need_i = need;
        step_dir_i = dir;
        wait_pass(c);
        pulses = 0;
        bad = 0;
        for (int i = 0; i < 4 * SLOT; i++) begin
            logic want;
            want = (i % SLOT == 0) && need[i / SLOT];
            if (step_o) pulses++;
            if (step_o != want) bad++;
            if (want && (step_drv_o != 2'(i / SLOT) || dir_o != dir[i / SLOT])) bad++;
            @(negedge clk);
        end
        act_prev = poll_act_o;
        chk(bad == 0, "R8 step timing/drive/dir", bad, 0);
        chk(pulses == $countones(need), "R8 step count", pulses, $countones(need));
        step_need_i = 4'b0000;
        step_dir_i = 4'b0000;
    endtask

    task automatic t_cmd_mid_pass();
        int c;
        int seen;
        do_reset();
        wait_pass(c);
        chk(rqm_o == 1'b1, "R9 rqm high in pass before byte", rqm_o, 1);
        cmd_byte_i = 1'b1;
        @(negedge clk);
        cmd_byte_i = 1'b0;
        chk(rqm_o == 1'b0, "R9 rqm held low", rqm_o, 0);
        wait_idle();
        chk(rqm_o == 1'b1, "R9 rqm after pass", rqm_o, 1);
        seen = 0;
        for (int i = 0; i < 3 * POLL; i++) begin
            @(negedge clk);
            if (poll_act_o) seen++;
        end
        chk(seen == 0, "R2 no pass in command phase", seen, 0);
        cmd_done_i = 1'b1;
        @(negedge clk);
        cmd_done_i = 1'b0;
        act_prev = 1'b0;
        wait_pass(c);
        chk(c > 0, "R2 passes resume", c, 1);
    endtask

    task automatic t_cmd_idle();
        int c;
        int bad;
        wait_idle();
        cmd_byte_i = 1'b1;
        @(negedge clk);
        cmd_byte_i = 1'b0;
        bad = 0;
        for (int i = 0; i < 3 * POLL; i++) begin
            if (poll_act_o || !rqm_o) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 idle command: rqm high, no pass", bad, 0);
        cmd_done_i = 1'b1;
        @(negedge clk);
        cmd_done_i = 1'b0;
        act_prev = 1'b0;
    endtask

    task automatic t_pwrdn();
        int c;
        do_reset();
        wait_idle();
        motor_off_i = 1'b1;
        auto_pd_en_i = 1'b0;
        for (int k = 0; k < PDW + 1; k++) wait_pass(c);
        chk(!pd_req_o, "R10 disabled no request", pd_req_o, 0);
        wait_idle();
        auto_pd_en_i = 1'b1;
        for (int k = 1; k <= PDW; k++) begin
            wait_pass(c);
            chk(pd_req_o == (k == PDW), $sformatf("R10 after pass %0d", k), pd_req_o, k == PDW);
        end
        motor_off_i = 1'b0;
        @(negedge clk);
        chk(!pd_req_o, "R10 clears on motor on", pd_req_o, 0);
        auto_pd_en_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset_state();
        t_rates();
        t_flags_sense();
        t_poll_disable();
        t_step(4'b1010, 4'b1000, 1'b0);
        t_step(4'b1111, 4'b0101, 1'b1);
        t_cmd_mid_pass();
        t_cmd_idle();
        t_pwrdn();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule